// File: doc/BRIEF.md
# Compare-Latch Conditional Branch Unit

This block serves the compare and conditional-branch pair of a 32-bit processor. A compare does not compute flags; it stores its two 32-bit register operands in a pair of operand latches, X (first operand) and Y (second operand). A later branch picks one of ten relations with a 4-bit condition code. It evaluates that relation on the stored pair and produces the next program counter.

The branch reads a 16-bit parcel. Bits 13:10 hold the condition code and bits 9:0 hold a signed half-word displacement. Codes outside the defined set do not redirect the PC. They raise an illegal-condition indication, and the next PC stays on the branch address so that a trap handler can see the faulting instruction. The outputs are combinational from the inputs and the latches. Only the latches hold state.

Top module: `cmp_branch_unit`

## Requirements
- R1: After reset both latches hold zero. With no compare since reset, a branch with code 0 (equal) is taken, and code 1 is not taken.
- R2: When cmp_valid is high on a clock edge, latch X takes cmp_a and latch Y takes cmp_b. When cmp_valid is low, both latches keep their values across any number of branches.
- R3: The displacement is parcel bits 9:0, sign-extended from 10 bits and multiplied by 2. The taken target is pc + 2 + displacement, modulo 2^32.
- R4: On a legal branch that is not taken, next_pc is pc + 2 and taken is 0.
- R5: Signed codes (two's complement): 2 means X<Y, 3 means X>Y, 6 means X>=Y, 7 means X<=Y.
- R6: Unsigned codes: 4 means X<Y, 5 means X>Y, 8 means X>=Y, 9 means X<=Y.
- R7: Equality codes: 0 means X==Y and 1 means X!=Y.
- R8: For codes 10 to 15 with br_valid high, illegal is 1, taken is 0 and next_pc equals pc.
- R9: When br_valid is low, taken and illegal are 0 and next_pc is pc + 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| cmp_valid | input | 1 | compare strobe |
| cmp_a | input | 32 | first compare operand |
| cmp_b | input | 32 | second compare operand |
| br_valid | input | 1 | branch strobe |
| br_parcel | input | 16 | branch parcel: [13:10] condition, [9:0] displacement |
| pc | input | 32 | address of the current instruction |
| next_pc | output | 32 | next program counter |
| taken | output | 1 | branch redirects |
| illegal | output | 1 | condition code undefined |

## Verification
A wrong latch value shows up only on a later branch, as a wrong taken bit, or as a next_pc pointing at the fall-through instead of the target. It becomes visible in the first branch after the corrupting edge whose relation separates the right and wrong pairs. For that reason the bench follows every compare with branches under all ten codes, with boundary operands such as equal values, sign-bit differences and all-ones. A wrong displacement shows in the same cycle as the branch and shows only when the branch is taken.

// File: rtl/cbu_pkg.sv
package cbu_pkg;
  localparam int XLEN = 32;
  localparam int PARCEL_W = 16;
  localparam int DISP_W = 10;
  localparam int COND_W = 4;
  localparam int COND_LSB = DISP_W;

  typedef enum logic [COND_W-1:0] {
    C_EQ  = 4'd0, C_NE  = 4'd1, C_SLT = 4'd2, C_SGT = 4'd3,
    C_ULT = 4'd4, C_UGT = 4'd5, C_SGE = 4'd6, C_SLE = 4'd7,
    C_UGE = 4'd8, C_ULE = 4'd9
  } cond_e;

  localparam logic [COND_W-1:0] LAST_LEGAL = 4'd9;

  function automatic logic [XLEN-1:0] disp_scaled(input logic [PARCEL_W-1:0] parcel);
    logic [XLEN-1:0] ext;
    ext = {{(XLEN-DISP_W){parcel[DISP_W-1]}}, parcel[DISP_W-1:0]};
    return ext << 1;
  endfunction

  function automatic logic eval_cond(input logic [COND_W-1:0] c,
                                     input logic [XLEN-1:0] x,
                                     input logic [XLEN-1:0] y);
    logic eq, slt, ult;
    eq  = (x == y);
    slt = ($signed(x) < $signed(y));
    ult = (x < y);
    case (c)
      C_EQ:    return eq;
      C_NE:    return !eq;
      C_SLT:   return slt;
      C_SGT:   return !slt && !eq;
      C_SGE:   return !slt;
      C_SLE:   return slt || eq;
      C_ULT:   return ult;
      C_UGT:   return !ult && !eq;
      C_UGE:   return !ult;
      C_ULE:   return ult || eq;
      default: return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/cbu_operand_latch.sv
module cbu_operand_latch #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] x_q,
  output logic [W-1:0] y_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      x_q <= '0;
      y_q <= '0;
    end else if (load) begin
      x_q <= a_in;
      y_q <= b_in;
    end
  end

  // R2
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> (x_q == $past(x_q)) && (y_q == $past(y_q)));
  // R2
  capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (x_q == $past(a_in)) && (y_q == $past(b_in)));
endmodule

// File: rtl/cbu_cond_eval.sv
module cbu_cond_eval
  import cbu_pkg::*;
(
  input  logic [COND_W-1:0] cond,
  input  logic [XLEN-1:0]   x,
  input  logic [XLEN-1:0]   y,
  output logic              hit,
  output logic              legal
);
  assign legal = (cond <= LAST_LEGAL);
  assign hit   = legal && eval_cond(cond, x, y);

  // R5 R6 R7: paired codes are exact complements
  always_comb begin
    if (cond == C_EQ) assert (hit != eval_cond(C_NE, x, y));
    if (cond == C_ULT) assert (hit != eval_cond(C_UGE, x, y));
    if (cond == C_SLT) assert (hit != eval_cond(C_SGE, x, y));
  end
endmodule

// File: rtl/cbu_next_pc.sv
module cbu_next_pc
  import cbu_pkg::*;
(
  input  logic [XLEN-1:0]     pc,
  input  logic [PARCEL_W-1:0] parcel,
  input  logic                active,
  input  logic                legal,
  input  logic                hit,
  output logic [XLEN-1:0]     next_pc,
  output logic                taken,
  output logic                illegal
);
  logic [XLEN-1:0] fall_thru;
  logic [XLEN-1:0] target;

  assign fall_thru = pc + XLEN'(2);
  assign target    = fall_thru + disp_scaled(parcel);
  assign illegal   = active && !legal;
  assign taken     = active && legal && hit;

  always_comb begin
    if (illegal)    next_pc = pc;
    else if (taken) next_pc = target;
    else            next_pc = fall_thru;
  end
endmodule

// File: rtl/cmp_branch_unit.sv
module cmp_branch_unit
  import cbu_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmp_valid,
  input  logic [31:0] cmp_a,
  input  logic [31:0] cmp_b,
  input  logic        br_valid,
  input  logic [15:0] br_parcel,
  input  logic [31:0] pc,
  output logic [31:0] next_pc,
  output logic        taken,
  output logic        illegal
);
  logic [XLEN-1:0]   lat_x, lat_y;
  logic [COND_W-1:0] cond_code;
  logic              cond_hit, cond_legal;

  assign cond_code = br_parcel[COND_LSB +: COND_W];

  cbu_operand_latch #(.W(XLEN)) u_latch (
    .clk(clk), .rst_n(rst_n), .load(cmp_valid),
    .a_in(cmp_a), .b_in(cmp_b), .x_q(lat_x), .y_q(lat_y));

  cbu_cond_eval u_eval (
    .cond(cond_code), .x(lat_x), .y(lat_y),
    .hit(cond_hit), .legal(cond_legal));

  cbu_next_pc u_npc (
    .pc(pc), .parcel(br_parcel), .active(br_valid),
    .legal(cond_legal), .hit(cond_hit),
    .next_pc(next_pc), .taken(taken), .illegal(illegal));

  // R8
  illegal_holds_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (next_pc == pc) && !taken);
  // R9
  idle_fallthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !br_valid |-> !taken && !illegal && (next_pc == pc + 32'd2));
  // R4
  not_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (br_valid && !illegal && !taken) |-> (next_pc == pc + 32'd2));
  // R2: strobes exclusive
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmp_valid && br_valid));
endmodule

// File: tb/cmp_branch_unit_tb.sv
module cmp_branch_unit_tb;
  logic clk = 0, rst_n = 0;
  logic cmp_valid = 0, br_valid = 0;
  logic [31:0] cmp_a = 0, cmp_b = 0, pc = 0;
  logic [15:0] br_parcel = 0;
  logic [31:0] next_pc;
  logic taken, illegal;
  int total = 0, bad = 0;
  logic [31:0] mx = 0, my = 0;

  always #10 clk = ~clk;

  cmp_branch_unit u_dut (.*);

  initial begin
    #4_000_000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  function automatic bit ref_rel(int c, logic [31:0] x, logic [31:0] y);
    int signed sx = x, sy = y;
    case (c)
      0: return x == y;     1: return x != y;
      2: return sx < sy;    3: return sx > sy;
      4: return x < y;      5: return x > y;
      6: return sx >= sy;   7: return sx <= sy;
      8: return x >= y;     9: return x <= y;
      default: return 0;
    endcase
  endfunction

  function automatic logic [31:0] ref_target(logic [31:0] p, logic [15:0] par);
    int signed d = int'($signed(par[9:0])) * 2;
    return p + 32'd2 + d;
  endfunction

  task automatic do_cmp(logic [31:0] a, logic [31:0] b);
    @(negedge clk);
    cmp_valid = 1; cmp_a = a; cmp_b = b;
    @(negedge clk);
    cmp_valid = 0; cmp_a = $urandom; cmp_b = $urandom;
    mx = a; my = b;
  endtask

  task automatic do_br(int c, logic [9:0] d, logic [31:0] p, string tag);
    logic [31:0] exp_pc; bit exp_t, exp_i;
    @(negedge clk);
    br_valid = 1; pc = p;
    br_parcel = {2'b11, 4'(c), d};
    #2;
    exp_i = (c > 9);
    exp_t = !exp_i && ref_rel(c, mx, my);
    exp_pc = exp_i ? p : (exp_t ? ref_target(p, br_parcel) : p + 32'd2);
    total++;
    if (taken !== exp_t || illegal !== exp_i || next_pc !== exp_pc) begin
      bad++;
      $display("FAIL %s code=%0d t=%b/%b i=%b/%b pc=%h exp %h", tag, c,
               taken, exp_t, illegal, exp_i, next_pc, exp_pc);
    end
    @(negedge clk); br_valid = 0;
  endtask

  task automatic all_codes(logic [31:0] p, string tag);
    for (int c = 0; c < 10; c++) do_br(c, 10'h005, p, tag);
  endtask

  initial begin
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    do_br(0, 10'h010, 32'h100, "R1");
    do_br(1, 10'h010, 32'h100, "R1");
    // R9 idle
    @(negedge clk); pc = 32'h4000; br_parcel = 16'h0400; #2;
    total++;
    if (taken || illegal || next_pc !== 32'h4002) begin
      bad++; $display("FAIL R9 t=%b i=%b pc=%h exp %h", taken, illegal, next_pc, 32'h4002);
    end
    // R7 R5 R6 directed
    do_cmp(32'h5, 32'h5);                   all_codes(32'h1000, "R7");
    do_cmp(32'h8000_0000, 32'h1);           all_codes(32'h1000, "R5");
    do_cmp(32'hFFFF_FFFF, 32'h0);           all_codes(32'h1000, "R6");
    do_cmp(32'h7FFF_FFFF, 32'h8000_0000);   all_codes(32'h1000, "R5");
    // R3 displacement extremes
    do_cmp(32'h1, 32'h1);
    do_br(0, 10'h1FF, 32'h2000, "R3");
    do_br(0, 10'h200, 32'h2000, "R3");
    do_br(0, 10'h3FF, 32'h0, "R3");
    do_br(0, 10'h000, 32'hFFFF_FFFE, "R3");
    // R4 not taken
    do_br(1, 10'h123, 32'h3000, "R4");
    // R8 illegal
    for (int c = 10; c < 16; c++) do_br(c, 10'h040, 32'h5000, "R8");
    // R2 hold over many branches
    do_cmp(32'h10, 32'h20);
    for (int k = 0; k < 12; k++) do_br(k % 10, 10'h004, 32'h600, "R2");
    // random
    for (int n = 0; n < 300; n++) begin
      logic [31:0] a = $urandom, b = $urandom;
      if (n % 4 == 0) b = a;
      if (n % 7 == 0) b = a ^ 32'h8000_0000;
      do_cmp(a, b);
      do_br(int'($urandom_range(0, 15)), 10'($urandom), $urandom, "R6");
      do_br(int'($urandom_range(0, 9)), 10'($urandom), $urandom, "R5");
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule